// File: doc/BRIEF.md
# Keyed Service Watchdog with Guarded Control Writes

This block is a watchdog that counts on a divided version of the system clock and asks for a system reset when software stops servicing it. It is live as soon as reset is released, with no setup needed. Software services it by writing a two-step key to the key register. Any stray key value triggers a reset request at once. So does any control write that does not carry the required guard pattern.

The block has four 8-bit registers on a 16-bit bus: a counter register that can only be read, a key register, a control register and an unused slot. The control register holds the rate select, the guard field, a disable bit and a sticky timeout flag. An external permission input decides whether software is allowed to switch the watchdog off. The block drives a reset request that lasts one clock. The system reset tree that acts on this request is outside the block.

Top module: `kwdt_top`

## Requirements
- R1: After reset is released, the counter reads 0, the control register reads 0x00 and the reset request is low. Counting starts on the first clock edge after release, with no register setup.
- R2: With rate select 0 or 1 (control bits [2:0]), the counter (address 0) rises by one every 512 clocks. It changes only by +1 steps or by returning to 0.
- R3: With rate select r between 2 and 7, the counter rises by one every 2^(8+r) clocks. For example, r=2 gives 1024 clocks and r=4 gives 4096 clocks.
- R4: A key-register write (address 1) of low byte 0xAA that directly follows a 0x55 key write clears the counter and the clock divider in that cycle. A 0xAA write with no 0x55 before it changes nothing and raises no request.
- R5: A key-register write whose low byte is neither 0x55 nor 0xAA raises the reset request for exactly the one cycle after the write edge.
- R6: A control-register write (address 2) whose bits [5:3] are not 3'b101 raises the reset request in the next cycle and leaves the control register unchanged.
- R7: A valid control write with bit 6 set disables the watchdog only while the permission input is 1. With permission at 0, the enable state does not change. While the watchdog is disabled, the counter holds its value.
- R8: When the counter wraps from 255 to 0, the reset request pulses for one cycle and control bit 7 is set. That bit stays set until a valid control write with bit 7 = 1 clears it.
- R9: Read data bits [15:8] are always 0. Bits [15:8] of write data are ignored. Writes to the counter address have no effect. The key register and address 3 read as 0. The guard field reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| dis_permit | input | 1 | When 1, software may disable the watchdog |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | 2 | Register address: 0 counter, 1 key, 2 control, 3 unused |
| wdata | input | 16 | Write data; only the low byte is used |
| rdata | output | 16 | Read data for `addr`; the upper byte is always zero |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest condition to reach from the ports is the counter overflow. At the fastest rate, the counter must climb through 256 steps of 512 clocks each, with no key write in between. The overflow test starts from a fresh reset and lets 131071 clocks pass untouched. It then checks that the counter reads 255 with no request, takes one more edge, and catches the one-cycle request, the wrap to 0 and the sticky flag. The rate tests first write the rate and then service the key pair. This zeroes the divider, so each counter step lands on a clock that the bench can compute.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   typedef enum logic [1:0] {
      RA_COUNT = 2'd0,
      RA_KEY   = 2'd1,
      RA_CTRL  = 2'd2,
      RA_SPARE = 2'd3
   } kwdt_addr_e;
endpackage

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
   parameter int BASE_LOG2 = 9,
   parameter int RATE_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              clr,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int RATES = 1 << RATE_W;
   localparam int PRE_W = BASE_LOG2 + RATES - 2;

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("kwdt_prescale: BASE_LOG2 must be at least 1");
   end
   if (RATE_W < 2) begin : g_bad_rate
      $error("kwdt_prescale: RATE_W must be at least 2");
   end

   logic [PRE_W-1:0] pre_q;
   logic [RATES-1:0] hit;

   for (genvar i = 0; i < RATES; i++) begin : g_rate
      localparam int L = (i < 2) ? BASE_LOG2 : BASE_LOG2 + i - 1;
      assign hit[i] = &pre_q[L-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (clr) pre_q <= '0;
      else if (run) pre_q <= pre_q + 1'b1;
   end

   assign tick = run & hit[rate];
endmodule

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq #(
   parameter int           KW       = 8,
   parameter logic [KW-1:0] KEY_ARM  = 8'h55,
   parameter logic [KW-1:0] KEY_FIRE = 8'hAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [KW-1:0] data,
   output logic          svc,
   output logic          bad
);
   if (KEY_ARM == KEY_FIRE) begin : g_bad_keys
      $error("kwdt_keyseq: the two key values must differ");
   end

   logic armed_q;
   logic is_arm, is_fire;

   assign is_arm  = wr && (data == KEY_ARM);
   assign is_fire = wr && (data == KEY_FIRE);
   assign svc     = is_fire && armed_q;
   assign bad     = wr && !is_arm && !is_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               armed_q <= 1'b0;
      else if (bad || is_fire)  armed_q <= 1'b0;
      else if (is_arm)          armed_q <= 1'b1;
   end
endmodule

// File: rtl/kwdt_ctlreg.sv
module kwdt_ctlreg #(
   parameter int                       REG_W   = 8,
   parameter int                       RATE_W  = 3,
   parameter logic [REG_W-RATE_W-3:0]  CHK_VAL = 3'b101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_W-1:0]  data,
   input  logic              permit,
   input  logic              ovf,
   output logic [RATE_W-1:0] rate,
   output logic              dis,
   output logic              flag,
   output logic              bad
);
   localparam int FLAG_BIT = REG_W - 1;
   localparam int DIS_BIT  = REG_W - 2;
   localparam int CHK_W    = REG_W - 2 - RATE_W;

   if (CHK_W < 1) begin : g_bad_split
      $error("kwdt_ctlreg: no room left for the guard field");
   end

   logic chk_ok, wr_ok;
   assign chk_ok = (data[RATE_W +: CHK_W] == CHK_VAL);
   assign wr_ok  = wr && chk_ok;
   assign bad    = wr && !chk_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate <= '0;
         dis  <= 1'b0;
         flag <= 1'b0;
      end else begin
         if (wr_ok) begin
            rate <= data[RATE_W-1:0];
            if (data[DIS_BIT]) begin
               if (permit) dis <= 1'b1;
            end else begin
               dis <= 1'b0;
            end
         end
         if (ovf)                        flag <= 1'b1;
         else if (wr_ok && data[FLAG_BIT]) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int                       DATA_W    = 16,
   parameter int                       REG_W     = 8,
   parameter int                       RATE_W    = 3,
   parameter int                       BASE_LOG2 = 9,
   parameter logic [REG_W-1:0]         KEY_ARM   = 8'h55,
   parameter logic [REG_W-1:0]         KEY_FIRE  = 8'hAA,
   parameter logic [REG_W-RATE_W-3:0]  CHK_VAL   = 3'b101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dis_permit,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              sys_rst_req
);
   localparam int CHK_W = REG_W - 2 - RATE_W;

   if (DATA_W <= REG_W) begin : g_bad_bus
      $error("kwdt_top: DATA_W must be wider than REG_W");
   end

   logic [REG_W-1:0]  wbyte;
   logic              unused_hi;
   logic              wr_key, wr_ctl;
   logic              svc, key_bad, chk_bad, tick, ovf;
   logic [RATE_W-1:0] rate;
   logic              dis_q, flag_q;
   logic [REG_W-1:0]  cnt_q;
   logic [REG_W-1:0]  rd_byte;

   assign wbyte     = wdata[REG_W-1:0];
   assign unused_hi = ^(wdata >> REG_W);
   assign wr_key    = wr_en && (kwdt_addr_e'(addr) == RA_KEY);
   assign wr_ctl    = wr_en && (kwdt_addr_e'(addr) == RA_CTRL);

   kwdt_keyseq #(.KW(REG_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_key (
      .clk(clk), .rst_n(rst_n), .wr(wr_key), .data(wbyte),
      .svc(svc), .bad(key_bad)
   );

   kwdt_prescale #(.BASE_LOG2(BASE_LOG2), .RATE_W(RATE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(!dis_q), .clr(svc),
      .rate(rate), .tick(tick)
   );

   kwdt_ctlreg #(.REG_W(REG_W), .RATE_W(RATE_W), .CHK_VAL(CHK_VAL)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(wr_ctl), .data(wbyte),
      .permit(dis_permit), .ovf(ovf),
      .rate(rate), .dis(dis_q), .flag(flag_q), .bad(chk_bad)
   );

   assign ovf = tick && (&cnt_q) && !svc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (svc)  cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sys_rst_req <= 1'b0;
      else        sys_rst_req <= ovf | key_bad | chk_bad;
   end

   always_comb begin
      case (kwdt_addr_e'(addr))
         RA_COUNT: rd_byte = cnt_q;
         RA_CTRL:  rd_byte = {flag_q, dis_q, {CHK_W{1'b0}}, rate};
         default:  rd_byte = '0;
      endcase
   end

   assign rdata = DATA_W'(rd_byte);
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
   import kwdt_pkg::*;
#(
   parameter int               DATA_W  = 16,
   parameter int               REG_W   = 8,
   parameter int               RATE_W  = 3,
   parameter logic [REG_W-1:0] KEY_ARM  = 8'h55,
   parameter logic [REG_W-1:0] KEY_FIRE = 8'hAA,
   parameter logic [REG_W-RATE_W-3:0] CHK_VAL = 3'b101
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              dis_permit,
   input logic              sys_rst_req,
   input logic [REG_W-1:0]  cnt,
   input logic              dis
);
   localparam int CHK_W = REG_W - 2 - RATE_W;

   logic key_wr, ctl_wr;
   assign key_wr = wr_en && (kwdt_addr_e'(addr) == RA_KEY);
   assign ctl_wr = wr_en && (kwdt_addr_e'(addr) == RA_CTRL);

   AST_UPPER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata >> REG_W) == '0); // R9

   AST_STRAY_KEY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && wdata[REG_W-1:0] != KEY_ARM && wdata[REG_W-1:0] != KEY_FIRE) |=> sys_rst_req); // R5

   AST_BAD_GUARD_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[RATE_W +: CHK_W] != CHK_VAL) |=> sys_rst_req); // R6

   AST_OFF_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dis) |-> $past(dis_permit)); // R7

   AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (dis && !key_wr) |=> $stable(cnt)); // R7

   AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == REG_W'($past(cnt) + 1'b1) || cnt == '0)); // R2
endmodule

bind kwdt_top kwdt_chk #(
   .DATA_W(DATA_W), .REG_W(REG_W), .RATE_W(RATE_W),
   .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE), .CHK_VAL(CHK_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .dis_permit(dis_permit), .sys_rst_req(sys_rst_req),
   .cnt(cnt_q), .dis(dis_q)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dis_permit = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'h0;
   logic [15:0] rdata;
   logic        sys_rst_req;

   int checks = 0;
   int failures = 0;

   kwdt_top dut (
      .clk(clk), .rst_n(rst_n), .dis_permit(dis_permit), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; dis_permit = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      do_reset();
      rd(2'd0, v); check("R1 counter after reset", v, 16'h0000);
      rd(2'd2, v); check("R1 control after reset", v, 16'h0000);
      check("R1 request after reset", {15'd0, sys_rst_req}, 16'h0000);
      step(511);
      rd(2'd0, v); check("R1 R2 count before 512 clocks", v, 16'h0000);
      step(1);
      rd(2'd0, v); check("R1 R2 count at 512 clocks", v, 16'h0001);
   endtask

   task automatic t_rate(input logic [2:0] r, input int period);
      logic [15:0] v;
      do_reset();
      wr(2'd2, {8'h00, 5'b00101, r});
      wr(2'd1, 16'h0055);
      wr(2'd1, 16'h00AA);
      rd(2'd0, v); check("R3 counter after service", v, 16'h0000);
      step(period - 1);
      rd(2'd0, v); check("R3 count one clock short", v, 16'h0000);
      step(1);
      rd(2'd0, v); check("R3 count at period", v, 16'h0001);
      rd(2'd2, v); check("R3 rate read back", v, {13'd0, r});
   endtask

   task automatic t_key();
      logic [15:0] v;
      do_reset();
      step(600);
      rd(2'd0, v); check("R4 counter before service", v, 16'h0001);
      wr(2'd1, 16'h00AA);
      check("R4 lone fire raises no request", {15'd0, sys_rst_req}, 16'h0000);
      rd(2'd0, v); check("R4 lone fire keeps counter", v, 16'h0001);
      wr(2'd1, 16'hFF55);
      check("R4 R9 arm with upper byte set", {15'd0, sys_rst_req}, 16'h0000);
      wr(2'd1, 16'h12AA);
      check("R4 pair raises no request", {15'd0, sys_rst_req}, 16'h0000);
      rd(2'd0, v); check("R4 pair clears counter", v, 16'h0000);
      step(100);
      wr(2'd0, 16'h0077);
      rd(2'd0, v); check("R9 counter write ignored", v, 16'h0000);
      rd(2'd1, v); check("R9 key register reads zero", v, 16'h0000);
      rd(2'd3, v); check("R9 spare address reads zero", v, 16'h0000);
   endtask

   task automatic t_bad_key();
      do_reset();
      wr(2'd1, 16'h5533);
      check("R5 stray key request", {15'd0, sys_rst_req}, 16'h0001);
      step(1);
      check("R5 request lasts one cycle", {15'd0, sys_rst_req}, 16'h0000);
   endtask

   task automatic t_bad_guard();
      logic [15:0] v;
      do_reset();
      wr(2'd2, 16'h0007);
      check("R6 bad guard request", {15'd0, sys_rst_req}, 16'h0001);
      rd(2'd2, v); check("R6 control unchanged", v, 16'h0000);
      step(1);
      check("R6 request drops", {15'd0, sys_rst_req}, 16'h0000);
      wr(2'd2, 16'hFF2B);
      check("R9 guarded write no request", {15'd0, sys_rst_req}, 16'h0000);
      rd(2'd2, v); check("R9 upper write byte ignored", v, 16'h0003);
   endtask

   task automatic t_disable();
      logic [15:0] v;
      do_reset();
      dis_permit = 1'b0;
      wr(2'd2, 16'h0068);
      rd(2'd2, v); check("R7 disable refused without permit", v, 16'h0000);
      dis_permit = 1'b1;
      wr(2'd2, 16'h0068);
      rd(2'd2, v); check("R7 disable taken with permit", v, 16'h0040);
      step(2000);
      rd(2'd0, v); check("R7 counter holds while off", v, 16'h0000);
      wr(2'd2, 16'h0028);
      rd(2'd2, v); check("R7 re-enable", v, 16'h0000);
      dis_permit = 1'b0;
   endtask

   task automatic t_overflow();
      logic [15:0] v;
      do_reset();
      step(131071);
      check("R8 no request before wrap", {15'd0, sys_rst_req}, 16'h0000);
      rd(2'd0, v); check("R8 counter at top", v, 16'h00FF);
      step(1);
      check("R8 wrap request", {15'd0, sys_rst_req}, 16'h0001);
      rd(2'd0, v); check("R8 counter wrapped", v, 16'h0000);
      rd(2'd2, v); check("R8 flag set", v, 16'h0080);
      step(1);
      check("R8 request one cycle", {15'd0, sys_rst_req}, 16'h0000);
      wr(2'd2, 16'h0028);
      rd(2'd2, v); check("R8 flag kept on zero write", v, 16'h0080);
      wr(2'd2, 16'h00A8);
      rd(2'd2, v); check("R8 flag cleared by one", v, 16'h0000);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_rate(3'd1, 512);
      t_rate(3'd2, 1024);
      t_rate(3'd4, 4096);
      t_key();
      t_bad_key();
      t_bad_guard();
      t_disable();
      t_overflow();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule